// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block holds the small control registers that a workstation I/O companion chip exposes to the host. It provides byte registers for configuration, diagnostics, modem control and two auxiliary functions, a 16-bit indicator register and a 32-bit system control word. The host reaches them over a plain register bus with an address, a size code, a write strobe and a read strobe. Read data is returned one cycle after the read strobe.

Several registers act on the system when written. One bit in the first auxiliary register fires a terminal-count strobe toward a floppy controller. The second auxiliary register issues a power-off request and acknowledges a latched power-fail condition. The system control word requests a system reset and keeps a status bit that records it. A write to the idle-controller location halts the CPU for one strobe.

A two-state machine tracks the power-fail condition. In `PF_CLEAR` no failure is latched. Transition `T_RAISE` goes to `PF_LATCHED` when the power-fail input changes to active while the interrupt enable is set. From `PF_LATCHED`, transition `T_DROP` returns to `PF_CLEAR` on any input change that does not meet that condition. Transition `T_ACK` returns to `PF_CLEAR` on an acknowledge write. There are two resets. Device reset leaves the diagnostic, indicator and system control registers unchanged. Power-on reset clears everything.

Top module: `aux_ctl_top`

## Requirements
- R1: `pf_irq` is high exactly when the latched power-fail status (aux2 bit 5) is set and the interrupt-enable bit (config bit 3) is set. Clearing config bit 3 lowers `pf_irq` without clearing the status.
- R2: On a cycle where `pfail_in` differs from its value in the previous cycle, the status becomes set if `pfail_in` is 1 and the stored config bit 3 is 1, and becomes clear otherwise. An input change in the same cycle as an acknowledge write decides the outcome.
- R3: A write to aux2 (address 0x04) keeps only data bit 0 (power-off). All other data bits are discarded. Aux2 reads as {bit 5 = status, bit 0 = power-off}, with the other bits 0.
- R4: A write to aux2 with data bit 1 set clears the latched status, provided no input change occurs in the same cycle. Bit 1 always reads back as 0.
- R5: A write to aux2 with data bit 0 set drives `shutdown_req` high for exactly one cycle, starting at the commit edge.
- R6: A write to aux1 (address 0x03) with data bit 1 set drives `fd_tc` high for one cycle. Aux1 stores the other seven bits and reads bit 1 as 0.
- R7: A 4-byte write at address 0x08 with data bit 0 set loads the system control word with 0x02 and pulses `sysrst_req` for one cycle. With bit 0 clear, the write changes nothing.
- R8: Addresses 0x09 to 0x0F (the rest of the system control region) read 0 and ignore writes.
- R9: Device reset (`rst_n` low with `por_n` high) clears config, modem, aux1 and aux2 (including status). It keeps diag, the indicator register and the system control word. Power-on reset clears all of them.
- R10: A byte write to address 0x05 pulses `cpu_halt` for one cycle. A read there returns 0.
- R11: Sizes are encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Bytes 0x00 to 0x05 need size 0, the indicator register at 0x06 needs size 1, and 0x08 to 0x0F need size 2. A mismatched access is ignored on write and returns 0 on read, and `bus_err` is high for one cycle.
- R12: Config (0x00), diag (0x01) and modem (0x02) store a full byte. The indicator register stores 16 bits. Unmapped addresses 0x10 to 0x1F read 0.
- R13: `bus_rdata` shows the selected value in the cycle after `bus_rd` and is 0 otherwise. A read in the cycle right after a write returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears all state |
| rst_n | input | 1 | Device reset, active low, synchronous, keeps retained registers |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data, right aligned |
| bus_rdata | output | DATA_W | Read data, one cycle after the read strobe |
| bus_err | output | 1 | One-cycle flag for a wrong access size |
| pfail_in | input | 1 | Power-fail indication |
| pf_irq | output | 1 | Power-fail interrupt |
| fd_tc | output | 1 | Floppy terminal-count strobe |
| shutdown_req | output | 1 | Power-off request strobe |
| sysrst_req | output | 1 | System reset request strobe |
| cpu_halt | output | 1 | CPU halt strobe |

## Verification
The power-fail input and an acknowledge write to aux2 can land in the same cycle. The bench raises `pfail_in` on the same edge that commits an aux2 write with bit 1 set, with the interrupt enabled. It expects `pf_irq` high and status bit 5 to read back set, because the input change takes precedence. The bench also checks the plain acknowledge, and the case where disabling the enable lowers the interrupt while the status stays latched.

// File: rtl/aux_ctl_pkg.sv
package aux_ctl_pkg;

    // byte addresses of the register bank
    localparam int A_CFG   = 0;
    localparam int A_DIAG  = 1;
    localparam int A_MODEM = 2;
    localparam int A_AUX1  = 3;
    localparam int A_AUX2  = 4;
    localparam int A_IDLE  = 5;
    localparam int A_LED   = 6;
    localparam int A_SYS   = 8;   // eight-byte region, word at offset 0

    // size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // bit positions that other logic decodes
    localparam int CFG_PIE_BIT   = 3;
    localparam int AUX1_TC_BIT   = 1;
    localparam int AUX2_OFF_BIT  = 0;
    localparam int AUX2_ACK_BIT  = 1;
    localparam int AUX2_STAT_BIT = 5;
    localparam int SYS_RST_BIT   = 0;
    localparam logic [7:0] SYS_RST_STATUS = 8'h02;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_DIAG,
        SEL_MODEM,
        SEL_AUX1,
        SEL_AUX2,
        SEL_IDLE,
        SEL_LED,
        SEL_SYS0,
        SEL_SYSX
    } sel_e;

    typedef enum logic {
        PF_CLEAR,
        PF_LATCHED
    } pf_state_e;

    typedef struct packed {
        sel_e sel;
        logic size_ok;
    } dec_t;

endpackage

// File: rtl/aux_ctl_decode.sv
module aux_ctl_decode
    import aux_ctl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);
    localparam int SYS_SPAN = 8;
    localparam int OFF_W    = $clog2(SYS_SPAN);
    localparam logic [ADDR_W-OFF_W-1:0] SYS_HI = (ADDR_W-OFF_W)'(A_SYS / SYS_SPAN);

    sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if (addr[ADDR_W-1:OFF_W] == SYS_HI) begin
            sel = (addr[OFF_W-1:0] == '0) ? SEL_SYS0 : SEL_SYSX;
        end else begin
            unique case (int'(addr))
                A_CFG:   sel = SEL_CFG;
                A_DIAG:  sel = SEL_DIAG;
                A_MODEM: sel = SEL_MODEM;
                A_AUX1:  sel = SEL_AUX1;
                A_AUX2:  sel = SEL_AUX2;
                A_IDLE:  sel = SEL_IDLE;
                A_LED:   sel = SEL_LED;
                default: sel = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        dec.sel = sel;
        unique case (sel)
            SEL_LED:            dec.size_ok = (size == SZ_HALF);
            SEL_SYS0, SEL_SYSX: dec.size_ok = (size == SZ_WORD);
            SEL_NONE:           dec.size_ok = 1'b1;
            default:            dec.size_ok = (size == SZ_BYTE);
        endcase
    end

endmodule

// File: rtl/aux_ctl_pfail.sv
module aux_ctl_pfail
    import aux_ctl_pkg::*;
(
    input  logic clk,
    input  logic dev_rst_n,
    input  logic pfail_in,
    input  logic pie,
    input  logic ack_wr,
    output logic pf_prev,
    output logic pf_stat
);
    pf_state_e state_q, state_d;
    logic      chg;

    assign chg = (pfail_in != pf_prev);

    // state register
    always_ff @(posedge clk) begin
        if (!dev_rst_n) begin
            state_q <= PF_CLEAR;
            pf_prev <= 1'b0;
        end else begin
            state_q <= state_d;
            pf_prev <= pfail_in;
        end
    end

    // transitions: an input change outranks an acknowledge in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_CLEAR: begin
                if (chg && pfail_in && pie) state_d = PF_LATCHED;         // T_RAISE
            end
            PF_LATCHED: begin
                if (chg) begin
                    if (!(pfail_in && pie)) state_d = PF_CLEAR;           // T_DROP
                end else if (ack_wr) begin
                    state_d = PF_CLEAR;                                   // T_ACK
                end
            end
            default: state_d = PF_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PF_LATCHED: pf_stat = 1'b1;
            default:    pf_stat = 1'b0;
        endcase
    end

endmodule

// File: rtl/aux_ctl_regs.sv
module aux_ctl_regs
    import aux_ctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LED_W  = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              dev_rst_n,
    input  logic              wr,
    input  logic              rd,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pf_stat,
    output logic              pie,
    output logic              ack_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              tc_pulse,
    output logic              off_pulse,
    output logic              rst_pulse,
    output logic              halt_pulse
);
    localparam int BYTE_W = 8;

    logic              wr_ok, rd_ok;
    logic [BYTE_W-1:0] cfg_q, diag_q, modem_q, aux1_q, sys_q;
    logic              off_q;
    logic [LED_W-1:0]  led_q;
    logic [BYTE_W-1:0] aux2_view;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:LED_W];

    assign wr_ok  = wr && dec.size_ok;
    assign rd_ok  = rd && dec.size_ok;
    assign pie    = cfg_q[CFG_PIE_BIT];
    assign ack_wr = wr_ok && (dec.sel == SEL_AUX2) && wdata[AUX2_ACK_BIT];

    always_comb begin
        aux2_view = '0;
        aux2_view[AUX2_STAT_BIT] = pf_stat;
        aux2_view[AUX2_OFF_BIT]  = off_q;
    end

    // registers cleared by device reset
    always_ff @(posedge clk) begin
        if (!dev_rst_n) begin
            cfg_q   <= '0;
            modem_q <= '0;
            aux1_q  <= '0;
            off_q   <= 1'b0;
        end else if (wr_ok) begin
            unique case (dec.sel)
                SEL_CFG:   cfg_q   <= wdata[BYTE_W-1:0];
                SEL_MODEM: modem_q <= wdata[BYTE_W-1:0];
                SEL_AUX1: begin
                    aux1_q              <= wdata[BYTE_W-1:0];
                    aux1_q[AUX1_TC_BIT] <= 1'b0;
                end
                SEL_AUX2:  off_q   <= wdata[AUX2_OFF_BIT];
                default: ;
            endcase
        end
    end

    // registers kept across device reset
    always_ff @(posedge clk) begin
        if (!por_n) begin
            diag_q <= '0;
            led_q  <= '0;
            sys_q  <= '0;
        end else if (wr_ok) begin
            unique case (dec.sel)
                SEL_DIAG: diag_q <= wdata[BYTE_W-1:0];
                SEL_LED:  led_q  <= wdata[LED_W-1:0];
                SEL_SYS0: if (wdata[SYS_RST_BIT]) sys_q <= SYS_RST_STATUS;
                default: ;
            endcase
        end
    end

    // strobes and error flag, one cycle wide
    always_ff @(posedge clk) begin
        if (!dev_rst_n) begin
            tc_pulse   <= 1'b0;
            off_pulse  <= 1'b0;
            rst_pulse  <= 1'b0;
            halt_pulse <= 1'b0;
            err        <= 1'b0;
        end else begin
            tc_pulse   <= wr_ok && (dec.sel == SEL_AUX1) && wdata[AUX1_TC_BIT];
            off_pulse  <= wr_ok && (dec.sel == SEL_AUX2) && wdata[AUX2_OFF_BIT];
            rst_pulse  <= wr_ok && (dec.sel == SEL_SYS0) && wdata[SYS_RST_BIT];
            halt_pulse <= wr_ok && (dec.sel == SEL_IDLE);
            err        <= (wr || rd) && !dec.size_ok;
        end
    end

    // registered read path
    always_ff @(posedge clk) begin
        if (!dev_rst_n) begin
            rdata <= '0;
        end else if (rd_ok) begin
            unique case (dec.sel)
                SEL_CFG:   rdata <= DATA_W'(cfg_q);
                SEL_DIAG:  rdata <= DATA_W'(diag_q);
                SEL_MODEM: rdata <= DATA_W'(modem_q);
                SEL_AUX1:  rdata <= DATA_W'(aux1_q);
                SEL_AUX2:  rdata <= DATA_W'(aux2_view);
                SEL_LED:   rdata <= DATA_W'(led_q);
                SEL_SYS0:  rdata <= DATA_W'(sys_q);
                default:   rdata <= '0;
            endcase
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/aux_ctl_top.sv
module aux_ctl_top
    import aux_ctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int LED_W  = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              pfail_in,
    output logic              pf_irq,
    output logic              fd_tc,
    output logic              shutdown_req,
    output logic              sysrst_req,
    output logic              cpu_halt
);
    logic dev_rst_n;
    dec_t dec;
    logic pie, ack_wr, pf_stat, pf_prev;

    assign dev_rst_n = por_n && rst_n;

    aux_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .dec  (dec)
    );

    aux_ctl_pfail u_pf (
        .clk       (clk),
        .dev_rst_n (dev_rst_n),
        .pfail_in  (pfail_in),
        .pie       (pie),
        .ack_wr    (ack_wr),
        .pf_prev   (pf_prev),
        .pf_stat   (pf_stat)
    );

    aux_ctl_regs #(.DATA_W(DATA_W), .LED_W(LED_W)) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .dev_rst_n  (dev_rst_n),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .dec        (dec),
        .wdata      (bus_wdata),
        .pf_stat    (pf_stat),
        .pie        (pie),
        .ack_wr     (ack_wr),
        .rdata      (bus_rdata),
        .err        (bus_err),
        .tc_pulse   (fd_tc),
        .off_pulse  (shutdown_req),
        .rst_pulse  (sysrst_req),
        .halt_pulse (cpu_halt)
    );

    assign pf_irq = pf_stat && pie;

endmodule

// File: rtl/aux_ctl_chk.sv
module aux_ctl_chk
    import aux_ctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              pfail_in,
    input logic              pf_prev,
    input logic              pf_irq,
    input logic              fd_tc,
    input logic              shutdown_req,
    input logic              sysrst_req,
    input logic              cpu_halt
);
    localparam logic [ADDR_W-1:0] AD_AUX1 = ADDR_W'(A_AUX1);
    localparam logic [ADDR_W-1:0] AD_AUX2 = ADDR_W'(A_AUX2);
    localparam logic [ADDR_W-1:0] AD_IDLE = ADDR_W'(A_IDLE);
    localparam logic [ADDR_W-1:0] AD_SYS  = ADDR_W'(A_SYS);

    a_r6_tc_from_write: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        fd_tc |-> $past(bus_wr && bus_addr == AD_AUX1 && bus_size == SZ_BYTE && bus_wdata[AUX1_TC_BIT]));

    a_r5_off_from_write: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        shutdown_req |-> $past(bus_wr && bus_addr == AD_AUX2 && bus_size == SZ_BYTE && bus_wdata[AUX2_OFF_BIT]));

    a_r7_rst_from_write: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        sysrst_req |-> $past(bus_wr && bus_addr == AD_SYS && bus_size == SZ_WORD && bus_wdata[SYS_RST_BIT]));

    a_r10_halt_from_write: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        cpu_halt |-> $past(bus_wr && bus_addr == AD_IDLE && bus_size == SZ_BYTE));

    a_r11_err_needs_access: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        bus_err |-> $past(bus_wr || bus_rd));

    a_r4_ack_lowers_irq: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (bus_wr && bus_addr == AD_AUX2 && bus_size == SZ_BYTE && bus_wdata[AUX2_ACK_BIT]
         && pfail_in == pf_prev) |=> !pf_irq);

    a_r13_rdata_quiet: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !$past(bus_rd) |-> bus_rdata == '0);

endmodule

bind aux_ctl_top aux_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/aux_ctl_top_tb_top.sv
module aux_ctl_top_tb_top;

    logic        clk = 1'b0;
    logic        por_n, rst_n;
    logic [4:0]  bus_addr;
    logic [1:0]  bus_size;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_err, pfail_in, pf_irq, fd_tc, shutdown_req, sysrst_req, cpu_halt;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    aux_ctl_top dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .pfail_in(pfail_in), .pf_irq(pf_irq), .fd_tc(fd_tc),
        .shutdown_req(shutdown_req), .sysrst_req(sysrst_req), .cpu_halt(cpu_halt)
    );

    // {rd, addr, size, value}: value is write data, or expected read data
    localparam int NV = 20;
    localparam logic [39:0] VECS [0:NV-1] = '{
        {1'b0, 5'h00, 2'd0, 32'h0000_00A5},   // R12 config
        {1'b1, 5'h00, 2'd0, 32'h0000_00A5},
        {1'b0, 5'h01, 2'd0, 32'h0000_003C},   // R12 diag
        {1'b1, 5'h01, 2'd0, 32'h0000_003C},
        {1'b0, 5'h02, 2'd0, 32'h0000_0077},   // R12 modem
        {1'b1, 5'h02, 2'd0, 32'h0000_0077},
        {1'b0, 5'h03, 2'd0, 32'h0000_00FF},   // R6 aux1 bit 1 dropped
        {1'b1, 5'h03, 2'd0, 32'h0000_00FD},
        {1'b0, 5'h06, 2'd1, 32'h0000_BEEF},   // R12 indicator
        {1'b1, 5'h06, 2'd1, 32'h0000_BEEF},
        {1'b0, 5'h04, 2'd0, 32'h0000_00FC},   // R3 aux2 keeps bit 0 only
        {1'b1, 5'h04, 2'd0, 32'h0000_0000},
        {1'b0, 5'h00, 2'd1, 32'h0000_00FF},   // R11 wrong size write
        {1'b1, 5'h00, 2'd0, 32'h0000_00A5},
        {1'b1, 5'h00, 2'd2, 32'h0000_0000},   // R11 wrong size read
        {1'b1, 5'h05, 2'd0, 32'h0000_0000},   // R10 idle read
        {1'b0, 5'h0C, 2'd2, 32'h0000_0001},   // R8 rest of region
        {1'b1, 5'h0C, 2'd2, 32'h0000_0000},
        {1'b1, 5'h08, 2'd2, 32'h0000_0000},   // R8 word unchanged
        {1'b1, 5'h10, 2'd0, 32'h0000_0000}    // R12 unmapped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_rd(input logic [4:0] a, input logic [1:0] s, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a; bus_size = s;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        por_n = 1'b0; rst_n = 1'b0;
        bus_addr = '0; bus_size = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        pfail_in = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // reset state (R9, R13)
        chk("R9 reset outputs", {26'b0, pf_irq, fd_tc, shutdown_req, sysrst_req, cpu_halt, bus_err}, 32'h0);
        chk("R13 idle rdata", bus_rdata, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][39]) begin
                do_rd(VECS[i][38:34], VECS[i][33:32], v);
                chk($sformatf("table vector %0d (R3 R6 R8 R10 R11 R12)", i), v, VECS[i][31:0]);
            end else begin
                do_wr(VECS[i][38:34], VECS[i][33:32], VECS[i][31:0]);
            end
        end

        // R6 terminal-count strobe
        do_wr(5'h03, 2'd0, 32'h02);
        chk("R6 tc high", fd_tc, 1);
        @(negedge clk);
        chk("R6 tc one cycle", fd_tc, 0);

        // R5 shutdown strobe and R13 read right after write
        do_wr(5'h04, 2'd0, 32'h01);
        chk("R5 shutdown high", shutdown_req, 1);
        do_rd(5'h04, 2'd0, v);
        chk("R13 read after write", v, 32'h01);
        chk("R5 shutdown one cycle", shutdown_req, 0);
        do_wr(5'h04, 2'd0, 32'h00);

        // R1 / R2 / R4 power-fail handling
        do_wr(5'h00, 2'd0, 32'h08);
        pfail_in = 1'b1;
        @(negedge clk);
        chk("R2 raise with enable", pf_irq, 1);
        do_rd(5'h04, 2'd0, v);
        chk("R3 status readback", v, 32'h20);
        do_wr(5'h04, 2'd0, 32'h02);
        chk("R4 ack lowers irq", pf_irq, 0);
        do_rd(5'h04, 2'd0, v);
        chk("R4 ack clears status", v, 32'h00);
        pfail_in = 1'b0;
        @(negedge clk);
        do_wr(5'h00, 2'd0, 32'h00);
        pfail_in = 1'b1;
        @(negedge clk);
        chk("R2 no latch without enable", pf_irq, 0);
        do_rd(5'h04, 2'd0, v);
        chk("R2 status stays clear", v, 32'h00);
        pfail_in = 1'b0;
        do_wr(5'h00, 2'd0, 32'h08);
        pfail_in = 1'b1;
        @(negedge clk);
        do_wr(5'h00, 2'd0, 32'h00);
        chk("R1 enable off lowers irq", pf_irq, 0);
        do_rd(5'h04, 2'd0, v);
        chk("R1 status kept", v, 32'h20);
        do_wr(5'h00, 2'd0, 32'h08);
        chk("R1 enable on raises irq", pf_irq, 1);
        pfail_in = 1'b0;
        @(negedge clk);
        chk("R2 drop clears", pf_irq, 0);

        // R2 same-cycle input change and acknowledge
        pfail_in = 1'b1;
        do_wr(5'h04, 2'd0, 32'h02);
        chk("R2 change beats ack", pf_irq, 1);
        do_rd(5'h04, 2'd0, v);
        chk("R2 status after race", v, 32'h20);

        // R7 system control
        do_wr(5'h08, 2'd2, 32'h0000_0000);
        chk("R7 no request without bit", sysrst_req, 0);
        do_rd(5'h08, 2'd2, v);
        chk("R7 word unchanged", v, 32'h0);
        do_wr(5'h08, 2'd2, 32'h0000_0005);
        chk("R7 request pulse", sysrst_req, 1);
        do_rd(5'h08, 2'd2, v);
        chk("R7 status loaded", v, 32'h02);
        chk("R7 request one cycle", sysrst_req, 0);

        // R10 halt strobe
        do_wr(5'h05, 2'd0, 32'h0);
        chk("R10 halt pulse", cpu_halt, 1);
        @(negedge clk);
        chk("R10 halt one cycle", cpu_halt, 0);

        // R11 error flag and ignored write
        do_wr(5'h06, 2'd0, 32'h1234);
        chk("R11 err flag", bus_err, 1);
        do_rd(5'h06, 2'd1, v);
        chk("R11 err one cycle", bus_err, 0);
        chk("R11 indicator untouched", v, 32'hBEEF);

        // R9 device reset keeps retained registers
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 irq cleared", pf_irq, 0);
        do_rd(5'h00, 2'd0, v); chk("R9 config cleared", v, 32'h0);
        do_rd(5'h02, 2'd0, v); chk("R9 modem cleared", v, 32'h0);
        do_rd(5'h03, 2'd0, v); chk("R9 aux1 cleared", v, 32'h0);
        do_rd(5'h04, 2'd0, v); chk("R9 aux2 cleared", v, 32'h0);
        do_rd(5'h01, 2'd0, v); chk("R9 diag kept", v, 32'h3C);
        do_rd(5'h06, 2'd1, v); chk("R9 indicator kept", v, 32'hBEEF);
        do_rd(5'h08, 2'd2, v); chk("R9 system word kept", v, 32'h02);

        // R9 power-on reset clears everything
        pfail_in = 1'b0;
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        do_rd(5'h01, 2'd0, v); chk("R9 diag cleared by power-on", v, 32'h0);
        do_rd(5'h08, 2'd2, v); chk("R9 system word cleared by power-on", v, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule